// File: doc/BRIEF.md
# Multi-Vector Replicated Lane Adder

This block holds a 32-entry vector register file and runs one kind of instruction on it. The instruction adds a single source vector, lane by lane, to every register of an aligned group of two or four consecutive registers. The sums overwrite that group. The lane width is chosen per instruction from a 2-bit size code. Each lane adds modulo its own width, and no carry passes into the next lane.

An instruction is handed over with a start pulse. The fields that come with it are the size code, a group-count selector, a group field and a 4-bit source index. The controller first reads the source register. It then reads each group register in turn and forms that register's sums into a holding buffer. It writes the buffer back only after every sum exists, so a source register that sits inside the destination group is seen with its original contents throughout. A one-cycle done pulse marks completion. A separate write port and a registered read port let the surrounding logic load and inspect the register file while the block is idle.

Top module: `mvadd_top`

## Requirements
- R1: The lane width is 8 << op_size: code 0 gives 8-bit lanes, 1 gives 16, 2 gives 32 and 3 gives 64. Every lane of every group register becomes (its own lane + the same-numbered lane of the source) modulo 2^width, and no carry crosses a lane boundary.
- R2: With op_quad = 0 the group is registers 2*op_grp and 2*op_grp+1. All other registers keep their values.
- R3: With op_quad = 1 the group is registers 4*op_grp[2:0] through 4*op_grp[2:0]+3, and op_grp[3] has no effect. All other registers keep their values.
- R4: The source register is op_src zero-extended, so only registers 0 to 15 can be the source. The source register is left unchanged when it lies outside the group.
- R5: When the source register lies inside the group, every group sum uses the source value from before the instruction.
- R6: done is a single-cycle pulse. Count the rising edge that samples start as edge 1. Then done is first high after edge 7 in two-register mode and after edge 11 in four-register mode, and the register file already holds the results when done is seen.
- R7: A start while an instruction is in progress is ignored. It neither alters the results nor produces an extra done.
- R8: If en is low when start is accepted, done and undef are both high after edge 1 and no register changes. undef is low on the done of a completed instruction.
- R9: After reset, done and undef are low and the block is idle.
- R10: ext_we writes ext_wdata to register ext_waddr when the block is idle and is ignored while busy. ext_rdata shows register ext_raddr one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Feature enable; low makes an instruction undefined |
| start | input | 1 | Instruction start pulse |
| op_size | input | 2 | Lane size code |
| op_quad | input | 1 | 0: two-register group, 1: four-register group |
| op_grp | input | 4 | Group field |
| op_src | input | 4 | Source register index |
| done | output | 1 | Completion pulse |
| undef | output | 1 | Instruction was undefined (with done) |
| ext_we | input | 1 | Register file write enable (idle only) |
| ext_waddr | input | 5 | Register file write address |
| ext_wdata | input | 128 | Register file write data |
| ext_raddr | input | 5 | Register file read address |
| ext_rdata | output | 128 | Registered read data |

## Verification
The hardest situation to reach is a source register that is also a group member, because the hazard appears only if a written-back sum feeds a later read. The bench reaches it with directed instructions whose source index falls at the start, middle and end of a group, and it also repeats the full size/mode/group sweep with rotating source indices that sometimes land in the group. A second case needs the port inputs to move mid-instruction. For it, the bench drives a fresh start and an external write during the read phase and then checks that neither shows up in the register file or on done.

// File: rtl/mvadd_pkg.sv
package mvadd_pkg;
  localparam int GMAX = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_RDSRC, ST_RDGRP, ST_WB} state_t;
endpackage

// File: rtl/mvadd_lane_alu.sv
module mvadd_lane_alu #(
  parameter int VLEN = 128
) (
  input  logic [VLEN-1:0] a,
  input  logic [VLEN-1:0] b,
  input  logic [1:0]      size,
  output logic [VLEN-1:0] sum
);
  logic [VLEN-1:0] part [4];

  for (genvar gi = 0; gi < 4; gi++) begin : g_size
    localparam int W = 8 << gi;
    localparam int L = VLEN / W;
    logic [VLEN-1:0] s;
    for (genvar l = 0; l < L; l++) begin : g_lane
      assign s[l*W +: W] = a[l*W +: W] + b[l*W +: W];
    end
    assign part[gi] = s;
  end

  assign sum = part[size];
endmodule

// File: rtl/mvadd_regfile.sv
module mvadd_regfile #(
  parameter int VLEN = 128,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [VLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  output logic [VLEN-1:0] rdata_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [VLEN-1:0] rdata_b
);
  logic [VLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/mvadd_top.sv
module mvadd_top
  import mvadd_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG),
  localparam int GW = AW - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            start,
  input  logic [1:0]      op_size,
  input  logic            op_quad,
  input  logic [GW-1:0]   op_grp,
  input  logic [GW-1:0]   op_src,
  output logic            done,
  output logic            undef,
  input  logic            ext_we,
  input  logic [AW-1:0]   ext_waddr,
  input  logic [VLEN-1:0] ext_wdata,
  input  logic [AW-1:0]   ext_raddr,
  output logic [VLEN-1:0] ext_rdata
);
  localparam int CW = $clog2(GMAX + 1);

  state_t          st;
  logic [1:0]      sz_q;
  logic            quad_q;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   src_q;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   cnt_m1;
  logic [CW-1:0]   nreg;
  logic [VLEN-1:0] opb;
  logic [VLEN-1:0] rbuf [GMAX];

  logic            busy;
  logic [AW-1:0]   ird_addr;
  logic [VLEN-1:0] ird_data;
  logic [VLEN-1:0] sum;
  logic            wb_we;
  logic [AW-1:0]   wb_addr;
  logic [VLEN-1:0] wb_data;
  logic            rf_we;
  logic [AW-1:0]   rf_waddr;
  logic [VLEN-1:0] rf_wdata;
  logic [AW-1:0]   start_base;

  assign busy     = (st != ST_IDLE);
  assign nreg     = quad_q ? CW'(4) : CW'(2);
  assign cnt_m1   = cnt - CW'(1);
  assign ird_addr = (st == ST_RDSRC) ? src_q : base_q + AW'(cnt);
  assign wb_we    = (st == ST_WB);
  assign wb_addr  = base_q + AW'(cnt);
  assign wb_data  = rbuf[cnt[1:0]];

  assign rf_we    = busy ? wb_we   : ext_we;
  assign rf_waddr = busy ? wb_addr : ext_waddr;
  assign rf_wdata = busy ? wb_data : ext_wdata;

  assign start_base = op_quad ? AW'({op_grp[GW-2:0], 2'b00})
                              : AW'({op_grp, 1'b0});

  mvadd_regfile #(.VLEN(VLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (ird_addr),
    .rdata_a (ird_data),
    .raddr_b (ext_raddr),
    .rdata_b (ext_rdata)
  );

  mvadd_lane_alu #(.VLEN(VLEN)) u_alu (
    .a    (ird_data),
    .b    (opb),
    .size (sz_q),
    .sum  (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      done   <= 1'b0;
      undef  <= 1'b0;
      cnt    <= '0;
      sz_q   <= '0;
      quad_q <= 1'b0;
      base_q <= '0;
      src_q  <= '0;
    end else begin
      done  <= 1'b0;
      undef <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (!en) begin
              done  <= 1'b1;
              undef <= 1'b1;
            end else begin
              sz_q   <= op_size;
              quad_q <= op_quad;
              base_q <= start_base;
              src_q  <= AW'(op_src);
              cnt    <= '0;
              st     <= ST_RDSRC;
            end
          end
        end
        ST_RDSRC: begin
          cnt <= '0;
          st  <= ST_RDGRP;
        end
        ST_RDGRP: begin
          if (cnt == '0) opb <= ird_data;
          else           rbuf[cnt_m1[1:0]] <= sum;
          if (cnt == nreg) begin
            cnt <= '0;
            st  <= ST_WB;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_WB: begin
          if (cnt == nreg - CW'(1)) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mvadd_chk.sv
module mvadd_chk #(
  parameter int AW = 5,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          undef,
  input logic          busy,
  input logic          wb_we,
  input logic          rf_we,
  input logic          quad_q,
  input logic [AW-1:0] wb_addr,
  input logic [CW-1:0] cnt
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_wb_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !undef) |-> $past(wb_we));

  p_undef_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    undef |-> done);

  p_undef_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    undef |-> !$past(wb_we));

  p_ext_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !wb_we) |-> !rf_we);

  p_pair_align_r2: assert property (@(posedge clk) disable iff (rst)
    (wb_we && !quad_q) |-> (wb_addr[0] == cnt[0]));

  p_quad_align_r3: assert property (@(posedge clk) disable iff (rst)
    (wb_we && quad_q) |-> (wb_addr[1:0] == cnt[1:0]));
endmodule

bind mvadd_top mvadd_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .done    (done),
  .undef   (undef),
  .busy    (busy),
  .wb_we   (wb_we),
  .rf_we   (rf_we),
  .quad_q  (quad_q),
  .wb_addr (wb_addr),
  .cnt     (cnt)
);

// File: tb/tb_mvadd_top.sv
module tb_mvadd_top;
  localparam int VLEN = 128;
  localparam int NREG = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1, start = 1'b0, op_quad = 1'b0, ext_we = 1'b0;
  logic [1:0] op_size = '0;
  logic [3:0] op_grp = '0, op_src = '0;
  logic [4:0] ext_waddr = '0, ext_raddr = '0;
  logic [VLEN-1:0] ext_wdata = '0;
  logic done, undef;
  logic [VLEN-1:0] ext_rdata;

  int n_tests = 0, n_fail = 0;
  logic [VLEN-1:0] model [NREG];
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  mvadd_top #(.VLEN(VLEN), .NREG(NREG)) dut (.*);

  task automatic chk(string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] lane_add(logic [VLEN-1:0] a, logic [VLEN-1:0] b, int sz);
    int w = 8 << sz;
    logic [VLEN-1:0] mask = (VLEN'(1) << w) - VLEN'(1);
    logic [VLEN-1:0] r = '0;
    for (int e = 0; e < VLEN / w; e++) begin
      logic [VLEN-1:0] la = (a >> (e * w)) & mask;
      logic [VLEN-1:0] lb = (b >> (e * w)) & mask;
      r |= ((la + lb) & mask) << (e * w);
    end
    return r;
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic ext_write(int a, logic [VLEN-1:0] d);
    @(negedge clk);
    ext_we = 1'b1; ext_waddr = 5'(a); ext_wdata = d;
    model[a] = d;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  task automatic check_all(string tag);
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      ext_raddr = 5'(r);
      @(negedge clk);
      chk($sformatf("%s reg%0d", tag, r), ext_rdata, model[r]);
    end
  endtask

  // One instruction; poke drives a stray start and a stray write mid-op (R7, R10)
  task automatic run_op(string tag, int sz, int q, int g, int s, bit ena, bit poke);
    int n = q ? 4 : 2;
    int base = q ? (g & 7) * 4 : g * 2;
    int edges = 1;
    int pulses = 0;
    logic [VLEN-1:0] tmp [4];
    @(negedge clk);
    op_size = 2'(sz); op_quad = q[0]; op_grp = 4'(g); op_src = 4'(s);
    en = ena; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && edges < 40) begin
      start  = poke && edges == 3;
      ext_we = poke && edges == 3;
      ext_waddr = 5'(base); ext_wdata = {VLEN/32{32'hDEAD_BEEF}};
      op_grp = poke ? 4'(g + 1) : op_grp;
      @(posedge clk); edges++;
      @(negedge clk);
      start = 1'b0; ext_we = 1'b0;
    end
    chk({tag, " R6 latency"}, 128'(edges), ena ? 128'(2 * n + 3) : 128'd1);
    chk({tag, " R8 undef"}, 128'(undef), 128'(!ena));
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk({tag, " R6/R7 single done"}, 128'(pulses), 128'd0);
    en = 1'b1;
    if (ena) begin
      for (int r = 0; r < n; r++) tmp[r] = lane_add(model[base + r], model[s], sz);
      for (int r = 0; r < n; r++) model[base + r] = tmp[r];
    end
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 done after reset", 128'(done), 128'd0);
    chk("R9 undef after reset", 128'(undef), 128'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 done idle", 128'(done), 128'd0);
    for (int r = 0; r < NREG; r++) begin
      logic [VLEN-1:0] v;
      for (int w = 0; w < VLEN / 32; w++) begin
        seed = nxt(seed);
        v[w*32 +: 32] = seed;
      end
      ext_write(r, v);
    end
    check_all("R10 load");
    // carry isolation at every lane width
    for (int sz = 0; sz < 4; sz++) begin
      ext_write(3, {VLEN/8{8'h01}});
      ext_write(8, '1);
      ext_write(9, '1);
      run_op("R1 carry", sz, 0, 4, 3, 1'b1, 1'b0);
    end
    // source index at top of its range, outside group
    run_op("R4 src15", 2, 0, 15, 15, 1'b1, 1'b0);
    run_op("R4 src0", 1, 1, 7, 0, 1'b1, 1'b0);
    // source inside group
    run_op("R5 overlap first", 0, 1, 1, 4, 1'b1, 1'b0);
    run_op("R5 overlap mid", 3, 1, 3, 14, 1'b1, 1'b0);
    run_op("R5 overlap last", 1, 0, 7, 15, 1'b1, 1'b0);
    run_op("R5 overlap pair", 2, 0, 2, 4, 1'b1, 1'b0);
    // busy start and write ignored
    run_op("R7 R10 busy", 1, 1, 2, 3, 1'b1, 1'b1);
    run_op("R7 R10 busy2", 0, 0, 5, 10, 1'b1, 1'b1);
    // disabled
    run_op("R8 disabled", 2, 1, 1, 2, 1'b0, 1'b0);
    // sweep
    for (int sz = 0; sz < 4; sz++)
      for (int q = 0; q < 2; q++)
        for (int g = 0; g < 16; g++)
          run_op(q ? "R3 sweep" : "R2 sweep", sz, q, g, (g * 5 + sz * 3 + q) % 16, 1'b1, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule